// File: doc/BRIEF.md
# Two-Level Nested Vectored Interrupt Controller

The block collects five interrupt requests: two active-low external pins, two timer overflow flags and one serial flag. The serial flag is the OR of a receive-done flag and a transmit-done flag. The enables, the priorities and the global enable gate these requests. The block then selects a single winner and presents that winner's code address to a CPU, together with a request line. When the CPU raises acknowledge, the controller records the winner's priority level as in service. It keeps that level in service until the CPU sends a return pulse.

There are two priority levels. A high-level request can interrupt a low-level routine. Nothing can interrupt a high-level routine. The CPU, the timers and the serial datapath are outside this block. They appear only as strobes, flags, the acknowledge and return inputs, and the presented vector.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is held and right after it, irq_req_o is 0, in_service_o is 2'b00 and both serial flags read 0.
- R2: Source index order is ext0=0, tmr0=1, ext1=2, tmr1=3, ser=4. The presented vector is 0x0003 + 8*index, so the vectors are 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R3: A source reaches irq_req_o only when glb_en_i is 1 and its src_en_i bit is 1. A pending flag held back by either gate stays pending and is presented once both gates are 1.
- R4: Among requests allowed at the same priority level, the lowest index wins. Any allowed high-level request beats every low-level request.
- R5: A src_prio_i bit of 1 means high level. A low-level request is presented only while in_service_o is 2'b00. A high-level request is presented only while in_service_o[1] is 0.
- R6: An accepted request (irq_req_o and irq_ack_i both 1 at a clock edge) sets in_service_o[1] for a high-level source or in_service_o[0] for a low-level source. A reti_i pulse clears the highest set bit of in_service_o.
- R7: An external source whose ext_edge_mode_i bit is 0 requests while its synchronized pin is low. It appears on irq_req_o on the third clock edge after the pin falls. If the pin is still low after return, it is requested again.
- R8: An external source whose ext_edge_mode_i bit is 1 latches a falling edge, even if the pin goes high again. It appears on irq_req_o on the fourth clock edge after the fall. Acceptance of its vector clears the latched edge.
- R9: A tmr_ovf_set_i pulse sets that timer's flag on the next edge, and the flag appears on irq_req_o one edge later. Acceptance of the timer's vector clears its flag.
- R10: Either serial flag raises the serial request. ser_rx_set_i and ser_tx_set_i set the flags. Only ser_rx_clr_i and ser_tx_clr_i clear them, and acceptance leaves them set.
- R11: On the edge after an acceptance, irq_req_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_pin_i | input | 2 | External request pins, active low, asynchronous |
| ext_edge_mode_i | input | 2 | Per pin: 1 = falling edge, 0 = low level |
| tmr_ovf_set_i | input | 2 | Timer wrap strobes |
| ser_rx_set_i | input | 1 | Receive-complete set strobe |
| ser_tx_set_i | input | 1 | Transmit-complete set strobe |
| ser_rx_clr_i | input | 1 | Software clear of the receive flag |
| ser_tx_clr_i | input | 1 | Software clear of the transmit flag |
| src_en_i | input | 5 | Per-source enable, indexed as in R2 |
| glb_en_i | input | 1 | Global enable |
| src_prio_i | input | 5 | Per-source level, 1 = high |
| irq_ack_i | input | 1 | CPU accepts the presented vector |
| reti_i | input | 1 | Return-from-interrupt pulse |
| irq_req_o | output | 1 | A vector is presented |
| irq_vec_o | output | 16 | Code address of the presented source |
| in_service_o | output | 2 | In-service bits: [1] high level, [0] low level |
| ser_rx_flag_o | output | 1 | Receive-complete flag |
| ser_tx_flag_o | output | 1 | Transmit-complete flag |

## Verification
If in-service state is left behind, the fault shows at the next return. Either a blocked request fails to appear one edge after the return pulse, or a request appears while a routine at its level is still running. A source flag that is not cleared on acceptance re-presents the same vector on the second edge after return. A flag that is wrongly cleared makes a still-set serial request vanish. Arbitration and vector arithmetic faults show directly on irq_vec_o on the edge the request is registered.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned NUM_EXT  = 2;
  localparam int unsigned NUM_TMR  = 2;
  localparam int unsigned NUM_SRC  = NUM_EXT + NUM_TMR + 1;
  localparam int unsigned IDX_W    = $clog2(NUM_SRC);
  localparam int unsigned VEC_W    = 16;
  localparam int unsigned NUM_LVL  = 2;

  typedef enum logic [IDX_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4
  } src_e;

  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } lvl_e;

  function automatic logic [VEC_W-1:0] vec_of(logic [IDX_W-1:0] idx,
                                               logic [VEC_W-1:0] base,
                                               logic [VEC_W-1:0] stride);
    return base + VEC_W'(idx) * stride;
  endfunction
endpackage

// File: rtl/prio_irq_sync.sv
module prio_irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic low_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign low_o  = ~chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/prio_irq_flags.sv
module prio_irq_flags
  import prio_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EXT-1:0] ext_low_i,
  input  logic [NUM_EXT-1:0] ext_fall_i,
  input  logic [NUM_EXT-1:0] ext_edge_mode_i,
  input  logic [NUM_TMR-1:0] tmr_set_i,
  input  logic               rx_set_i,
  input  logic               tx_set_i,
  input  logic               rx_clr_i,
  input  logic               tx_clr_i,
  input  logic [NUM_SRC-1:0] ack_hit_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               rx_flag_o,
  output logic               tx_flag_o
);
  // ext k sits at index 2k, timer k at 2k+1, serial last
  for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
    logic edge_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 edge_q <= 1'b0;
      else if (!ext_edge_mode_i[k]) edge_q <= 1'b0;
      else if (ext_fall_i[k])      edge_q <= 1'b1;
      else if (ack_hit_i[2*k])     edge_q <= 1'b0;
    end
    assign pend_o[2*k] = ext_edge_mode_i[k] ? edge_q : ext_low_i[k];
  end

  for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
    logic ovf_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               ovf_q <= 1'b0;
      else if (tmr_set_i[k])     ovf_q <= 1'b1;
      else if (ack_hit_i[2*k+1]) ovf_q <= 1'b0;
    end
    assign pend_o[2*k+1] = ovf_q;
  end

  logic rx_q, tx_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q <= 1'b0;
      tx_q <= 1'b0;
    end else begin
      if (rx_set_i)      rx_q <= 1'b1;
      else if (rx_clr_i) rx_q <= 1'b0;
      if (tx_set_i)      tx_q <= 1'b1;
      else if (tx_clr_i) tx_q <= 1'b0;
    end
  end

  assign pend_o[NUM_SRC-1] = rx_q | tx_q;
  assign rx_flag_o = rx_q;
  assign tx_flag_o = tx_q;
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
  import prio_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               glb_en_i,
  input  logic [NUM_SRC-1:0] prio_i,
  input  logic [NUM_LVL-1:0] isr_i,
  output logic               win_vld_o,
  output logic [IDX_W-1:0]   win_idx_o,
  output lvl_e               win_lvl_o
);
  logic [NUM_SRC-1:0] elig, hi_ok, lo_ok;

  function automatic logic [IDX_W-1:0] first_set(logic [NUM_SRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  always_comb begin
    elig  = pend_i & en_i & {NUM_SRC{glb_en_i}};
    hi_ok = elig & prio_i & {NUM_SRC{~isr_i[LVL_HI]}};
    lo_ok = elig & ~prio_i & {NUM_SRC{isr_i == '0}};
    if (|hi_ok) begin
      win_vld_o = 1'b1;
      win_idx_o = first_set(hi_ok);
      win_lvl_o = LVL_HI;
    end else begin
      win_vld_o = |lo_ok;
      win_idx_o = first_set(lo_ok);
      win_lvl_o = LVL_LO;
    end
  end
endmodule

// File: rtl/prio_irq_isr.sv
module prio_irq_isr
  import prio_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               accept_i,
  input  lvl_e               lvl_i,
  input  logic               reti_i,
  output logic [NUM_LVL-1:0] isr_o
);
  logic [NUM_LVL-1:0] isr_q, after_ret;

  // drop the top level first
  always_comb begin
    after_ret = isr_q;
    if (reti_i) begin
      if (isr_q[LVL_HI]) after_ret[LVL_HI] = 1'b0;
      else               after_ret[LVL_LO] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       isr_q <= '0;
    else if (accept_i) isr_q <= after_ret | (NUM_LVL'(1) << lvl_i);
    else               isr_q <= after_ret;
  end

  assign isr_o = isr_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [VEC_W-1:0] VEC_BASE    = 16'h0003,
  parameter logic [VEC_W-1:0] VEC_STRIDE  = 16'h0008
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_EXT-1:0]   ext_pin_i,
  input  logic [NUM_EXT-1:0]   ext_edge_mode_i,
  input  logic [NUM_TMR-1:0]   tmr_ovf_set_i,
  input  logic                 ser_rx_set_i,
  input  logic                 ser_tx_set_i,
  input  logic                 ser_rx_clr_i,
  input  logic                 ser_tx_clr_i,
  input  logic [NUM_SRC-1:0]   src_en_i,
  input  logic                 glb_en_i,
  input  logic [NUM_SRC-1:0]   src_prio_i,
  input  logic                 irq_ack_i,
  input  logic                 reti_i,
  output logic                 irq_req_o,
  output logic [VEC_W-1:0]     irq_vec_o,
  output logic [NUM_LVL-1:0]   in_service_o,
  output logic                 ser_rx_flag_o,
  output logic                 ser_tx_flag_o
);
  logic [NUM_EXT-1:0] ext_low, ext_fall;
  logic [NUM_SRC-1:0] pend, ack_hit;
  logic               win_vld;
  logic [IDX_W-1:0]   win_idx;
  lvl_e               win_lvl;
  logic [NUM_LVL-1:0] isr;

  logic               req_q;
  logic [IDX_W-1:0]   idx_q;
  lvl_e               lvl_q;
  logic               accept;

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_sync
    prio_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (ext_pin_i[k]),
      .low_o  (ext_low[k]),
      .fall_o (ext_fall[k])
    );
  end

  prio_irq_flags u_flags (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .ext_low_i       (ext_low),
    .ext_fall_i      (ext_fall),
    .ext_edge_mode_i (ext_edge_mode_i),
    .tmr_set_i       (tmr_ovf_set_i),
    .rx_set_i        (ser_rx_set_i),
    .tx_set_i        (ser_tx_set_i),
    .rx_clr_i        (ser_rx_clr_i),
    .tx_clr_i        (ser_tx_clr_i),
    .ack_hit_i       (ack_hit),
    .pend_o          (pend),
    .rx_flag_o       (ser_rx_flag_o),
    .tx_flag_o       (ser_tx_flag_o)
  );

  prio_irq_arb u_arb (
    .pend_i    (pend),
    .en_i      (src_en_i),
    .glb_en_i  (glb_en_i),
    .prio_i    (src_prio_i),
    .isr_i     (isr),
    .win_vld_o (win_vld),
    .win_idx_o (win_idx),
    .win_lvl_o (win_lvl)
  );

  assign accept  = req_q & irq_ack_i;
  assign ack_hit = accept ? (NUM_SRC'(1) << idx_q) : '0;

  prio_irq_isr u_isr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .lvl_i    (lvl_q),
    .reti_i   (reti_i),
    .isr_o    (isr)
  );

  // registered presentation; withdrawn for one edge after acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      idx_q <= '0;
      lvl_q <= LVL_LO;
    end else begin
      req_q <= win_vld & ~accept;
      idx_q <= win_idx;
      lvl_q <= win_lvl;
    end
  end

  assign irq_req_o    = req_q;
  assign irq_vec_o    = vec_of(idx_q, VEC_BASE, VEC_STRIDE);
  assign in_service_o = isr;
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        irq_req_o,
  input logic        irq_ack_i,
  input logic [15:0] irq_vec_o,
  input logic [1:0]  in_service_o,
  input logic        reti_i,
  input logic        glb_en_i,
  input logic        ser_rx_set_i,
  input logic        ser_rx_clr_i,
  input logic        ser_rx_flag_o
);
  // R11
  ack_drops_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && irq_ack_i) |=> !irq_req_o);

  // R5
  no_req_in_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> !in_service_o[1]);

  // R2
  vec_on_grid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_vec_o[2:0] == 3'd3 && irq_vec_o <= 16'h0023));

  // R3
  glb_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> $past(glb_en_i));

  // R6
  reti_top_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && in_service_o == 2'b11) |=> in_service_o == 2'b01);

  // R10
  ack_keeps_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && ser_rx_flag_o && !ser_rx_clr_i && !ser_rx_set_i) |=> ser_rx_flag_o);
endmodule

bind prio_irq_ctrl prio_irq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .irq_req_o     (irq_req_o),
  .irq_ack_i     (irq_ack_i),
  .irq_vec_o     (irq_vec_o),
  .in_service_o  (in_service_o),
  .reti_i        (reti_i),
  .glb_en_i      (glb_en_i),
  .ser_rx_set_i  (ser_rx_set_i),
  .ser_rx_clr_i  (ser_rx_clr_i),
  .ser_rx_flag_o (ser_rx_flag_o)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  ext_pin_i = 2'b11;
  logic [1:0]  ext_edge_mode_i = 2'b00;
  logic [1:0]  tmr_ovf_set_i = 2'b00;
  logic        ser_rx_set_i = 1'b0, ser_tx_set_i = 1'b0;
  logic        ser_rx_clr_i = 1'b0, ser_tx_clr_i = 1'b0;
  logic [4:0]  src_en_i = 5'h1F;
  logic        glb_en_i = 1'b1;
  logic [4:0]  src_prio_i = 5'h00;
  logic        irq_ack_i = 1'b0, reti_i = 1'b0;
  logic        irq_req_o;
  logic [15:0] irq_vec_o;
  logic [1:0]  in_service_o;
  logic        ser_rx_flag_o, ser_tx_flag_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  prio_irq_ctrl u_dut (
    .clk_i, .rst_ni, .ext_pin_i, .ext_edge_mode_i, .tmr_ovf_set_i,
    .ser_rx_set_i, .ser_tx_set_i, .ser_rx_clr_i, .ser_tx_clr_i,
    .src_en_i, .glb_en_i, .src_prio_i, .irq_ack_i, .reti_i,
    .irq_req_o, .irq_vec_o, .in_service_o, .ser_rx_flag_o, .ser_tx_flag_o
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic expect_vec(input string tag, input logic [15:0] v);
    check({tag, " req"}, 32'(irq_req_o), 32'd1);
    check({tag, " vec"}, 32'(irq_vec_o), 32'(v));
  endtask

  task automatic do_ack();
    irq_ack_i = 1'b1;
    step(1);
    irq_ack_i = 1'b0;
    check("R11 req after ack", 32'(irq_req_o), 32'd0);
  endtask

  task automatic do_reti();
    reti_i = 1'b1;
    step(1);
    reti_i = 1'b0;
  endtask

  task automatic t_reset();
    step(2);
    check("R1 req in reset", 32'(irq_req_o), 32'd0);
    check("R1 isr in reset", 32'(in_service_o), 32'd0);
    rst_ni = 1'b1;
    step(1);
    check("R1 req after reset", 32'(irq_req_o), 32'd0);
    check("R1 ser flags", 32'({ser_rx_flag_o, ser_tx_flag_o}), 32'd0);
  endtask

  task automatic t_timer();
    tmr_ovf_set_i[0] = 1'b1;
    step(1);
    tmr_ovf_set_i[0] = 1'b0;
    check("R9 not yet", 32'(irq_req_o), 32'd0);
    step(1);
    expect_vec("R9 R2 tmr0", 16'h000B);
    do_ack();
    check("R6 isr low set", 32'(in_service_o), 32'd1);
    step(3);
    check("R11 held off", 32'(irq_req_o), 32'd0);
    do_reti();
    check("R6 isr cleared", 32'(in_service_o), 32'd0);
    step(3);
    check("R9 flag cleared by ack", 32'(irq_req_o), 32'd0);
  endtask

  task automatic t_gates();
    glb_en_i = 1'b0;
    tmr_ovf_set_i[1] = 1'b1;
    step(1);
    tmr_ovf_set_i[1] = 1'b0;
    step(4);
    check("R3 global off", 32'(irq_req_o), 32'd0);
    glb_en_i = 1'b1;
    step(1);
    expect_vec("R3 R2 tmr1 after glb", 16'h001B);
    do_ack(); do_reti();
    src_en_i[4] = 1'b0;
    ser_rx_set_i = 1'b1;
    step(1);
    ser_rx_set_i = 1'b0;
    step(4);
    check("R3 source off", 32'(irq_req_o), 32'd0);
    check("R10 rx flag", 32'(ser_rx_flag_o), 32'd1);
    src_en_i[4] = 1'b1;
    step(1);
    expect_vec("R3 R2 ser after en", 16'h0023);
    do_ack();
    check("R10 rx kept on ack", 32'(ser_rx_flag_o), 32'd1);
    do_reti();
    step(1);
    expect_vec("R10 ser again", 16'h0023);
    ser_rx_clr_i = 1'b1;
    step(1);
    ser_rx_clr_i = 1'b0;
    check("R10 rx cleared", 32'(ser_rx_flag_o), 32'd0);
    step(2);
    check("R10 no ser req", 32'(irq_req_o), 32'd0);
    ser_tx_set_i = 1'b1;
    step(1);
    ser_tx_set_i = 1'b0;
    step(1);
    expect_vec("R10 tx raises ser", 16'h0023);
    ser_tx_clr_i = 1'b1;
    step(1);
    ser_tx_clr_i = 1'b0;
    step(2);
    check("R10 tx cleared", 32'(irq_req_o), 32'd0);
  endtask

  task automatic t_ties();
    tmr_ovf_set_i = 2'b11;
    ser_tx_set_i  = 1'b1;
    step(1);
    tmr_ovf_set_i = 2'b00;
    ser_tx_set_i  = 1'b0;
    step(1);
    expect_vec("R4 first tmr0", 16'h000B);
    do_ack(); do_reti(); step(1);
    expect_vec("R4 then tmr1", 16'h001B);
    do_ack(); do_reti(); step(1);
    expect_vec("R4 then ser", 16'h0023);
    do_ack();
    ser_tx_clr_i = 1'b1;
    do_reti();
    ser_tx_clr_i = 1'b0;
    step(2);
    check("R4 all served", 32'(irq_req_o), 32'd0);
  endtask

  task automatic t_nest();
    src_prio_i = 5'b01000;
    tmr_ovf_set_i[0] = 1'b1;
    step(1);
    tmr_ovf_set_i[0] = 1'b0;
    step(1);
    expect_vec("R5 low tmr0", 16'h000B);
    do_ack();
    tmr_ovf_set_i[1] = 1'b1;
    step(1);
    tmr_ovf_set_i[1] = 1'b0;
    step(1);
    expect_vec("R5 high preempts", 16'h001B);
    do_ack();
    check("R6 both in service", 32'(in_service_o), 32'd3);
    tmr_ovf_set_i = 2'b11;
    step(1);
    tmr_ovf_set_i = 2'b00;
    step(4);
    check("R5 high blocks all", 32'(irq_req_o), 32'd0);
    do_reti();
    check("R6 high cleared first", 32'(in_service_o), 32'd1);
    step(1);
    expect_vec("R5 high after return", 16'h001B);
    do_ack();
    do_reti();
    step(3);
    check("R5 low blocked by low", 32'(irq_req_o), 32'd0);
    do_reti();
    check("R6 low cleared", 32'(in_service_o), 32'd0);
    step(1);
    expect_vec("R5 low after return", 16'h000B);
    do_ack(); do_reti();
    src_prio_i = 5'b00000;
    step(2);
    check("R5 idle", 32'(irq_req_o), 32'd0);
  endtask

  task automatic t_level();
    ext_edge_mode_i[0] = 1'b0;
    ext_pin_i[0] = 1'b0;
    step(2);
    check("R7 not yet", 32'(irq_req_o), 32'd0);
    step(1);
    expect_vec("R7 R2 ext0 level", 16'h0003);
    do_ack(); do_reti(); step(1);
    expect_vec("R7 re-raised", 16'h0003);
    do_ack();
    ext_pin_i[0] = 1'b1;
    step(3);
    do_reti();
    step(3);
    check("R7 pin released", 32'(irq_req_o), 32'd0);
  endtask

  task automatic t_edge();
    ext_edge_mode_i[1] = 1'b1;
    step(2);
    ext_pin_i[1] = 1'b0;
    step(1);
    ext_pin_i[1] = 1'b1;
    step(2);
    check("R8 not yet", 32'(irq_req_o), 32'd0);
    step(1);
    expect_vec("R8 R2 ext1 edge", 16'h0013);
    step(3);
    expect_vec("R8 latched", 16'h0013);
    do_ack(); do_reti();
    step(3);
    check("R8 cleared by ack", 32'(irq_req_o), 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_timer();
    t_gates();
    t_ties();
    t_nest();
    t_level();
    t_edge();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule